// File: doc/BRIEF.md
# Prefetch Burst Serializer and Deserializer

This block sits between a memory core and its narrow data pins. The core moves one wide word per access. The pins move a quarter of that word per beat, with two beats per core clock. The block is modelled at beat rate: its clock `clk` ticks once per half core cycle, so each beat lasts one `clk` cycle.

On the read side, the core offers a word through a valid/ready handshake. The block accepts it only when it is idle. It then drives a strobe low for one preamble beat. After that it emits the four slices of the word, lowest slice first. The strobe changes level at every beat boundary, so its edges line up with the data changes.

On the write side, the controller drives data and one strobe per byte lane. The strobe is centred on each beat. The block takes a beat whenever the sampled strobe level of a lane differs from its previous sample. Once every lane holds four beats, the block hands the assembled word to the core as a single-cycle pulse. Each lane fills on its own strobe, so the lanes may be skewed against each other.

Top module: `burst_serdes`

## Requirements
- R1: While reset is held and in the first cycle after it, `rdReady` is 1 and `dqOe`, `dqsOe` and `wrValid` are 0.
- R2: A word is accepted in a cycle with `rdValid` and `rdReady` both 1. In the next cycle the block is in preamble: `dqsOe`=1, every bit of `dqsOut` is 0, and `dqOe`=0.
- R3: The four cycles after the preamble carry the accepted word on `dqOut` with `dqOe`=1. Beat k carries bits [k*DQ_W +: DQ_W], for k = 0, 1, 2, 3 in that order.
- R4: On reads every bit of `dqsOut` is 1 on beats 0 and 2 and 0 on beats 1 and 3. The strobe therefore changes level at each beat boundary.
- R5: After the fourth beat, `dqOe` and `dqsOe` fall together in the same cycle.
- R6: `rdReady` is 1 exactly when `dqsOe` is 0. A word offered during a burst is not taken, and no preamble follows from it.
- R7: `dqOut` is all zeros whenever `dqOe` is 0.
- R8: While `wrActive` is 1, a lane takes its slice of `dqIn` in each cycle where its `dqsIn` bit differs from the previous sample. The idle strobe level is 0. Beat k of lane l lands at bits [k*DQ_W + l*LANE_W +: LANE_W] of `wrWord`.
- R9: `wrValid` rises one cycle after the last lane samples its fourth strobe change. It stays high for exactly one cycle. Lanes may take their beats in different cycles.
- R10: Setting `wrActive` to 0 discards any partly collected beats in all lanes. The strobe history restarts at level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat-rate clock (two ticks per core cycle) |
| rstN | input | 1 | Active-low synchronous reset |
| rdValid | input | 1 | Core offers a read word |
| rdReady | output | 1 | Block is idle and takes the offered word |
| rdWord | input | WORD_W | Core read word, four beats wide |
| wrActive | input | 1 | Controller is driving write strobes |
| dqsIn | input | LANES | Write strobe, one per byte lane |
| dqIn | input | DQ_W | Write data at the pins |
| wrValid | output | 1 | One-cycle pulse: assembled write word ready |
| wrWord | output | WORD_W | Assembled write word |
| dqOut | output | DQ_W | Read data at the pins |
| dqOe | output | 1 | Read data drive enable |
| dqsOut | output | LANES | Read strobe, one per byte lane |
| dqsOe | output | 1 | Read strobe drive enable |

## Verification
A read state machine that loses track of its beat count shows up at the pins within one beat. The symptoms are a strobe that fails to toggle, a burst shorter or longer than four, or `rdReady` that disagrees with `dqsOe`. A slip in the read shift register shows up as a wrong slice on the very next beat. On the write side, a lane counter that misses or doubles a strobe change either leaves `wrValid` silent or produces a word with beats out of place. That shows one cycle after the burst ends. Skewed lanes and aborted bursts check that every lane keeps its own count and that an abort clears all of them.

// File: rtl/burst_serdes_pkg.sv
package burst_serdes_pkg;
  localparam int BEATS = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_BEAT
  } rdState_t;

  typedef struct packed {
    logic load;
    logic shift;
    logic dqOe;
    logic dqsOe;
    logic dqsLevel;
    logic wrPush;
  } pfsCtl_t;
endpackage

// File: rtl/burst_serdes_ctrl.sv
module burst_serdes_ctrl
  import burst_serdes_pkg::*;
#(
  parameter int LANES = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdValid,
  output logic             rdReady,
  input  logic [LANES-1:0] laneFull,
  output pfsCtl_t          ctl
);
  localparam int CNT_W = $clog2(BEATS);

  rdState_t   state;
  logic [CNT_W-1:0] beatCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      beatCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (rdValid) state <= ST_PRE;
        ST_PRE: begin
          state   <= ST_BEAT;
          beatCnt <= '0;
        end
        ST_BEAT: begin
          beatCnt <= beatCnt + 1'b1;
          if (beatCnt == CNT_W'(BEATS - 1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rdReady      = (state == ST_IDLE);
    ctl.load     = rdValid && rdReady;
    ctl.shift    = (state == ST_BEAT);
    ctl.dqOe     = (state == ST_BEAT);
    ctl.dqsOe    = (state != ST_IDLE);
    ctl.dqsLevel = (state == ST_BEAT) && !beatCnt[0];
    ctl.wrPush   = &laneFull;
  end
endmodule

// File: rtl/burst_serdes_dp.sv
module burst_serdes_dp
  import burst_serdes_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANES  = 1,
  localparam int DQ_W   = LANE_W * LANES,
  localparam int WORD_W = DQ_W * BEATS
) (
  input  logic              clk,
  input  logic              rstN,
  input  pfsCtl_t           ctl,
  input  logic [WORD_W-1:0] rdWord,
  input  logic              wrActive,
  input  logic [LANES-1:0]  dqsIn,
  input  logic [DQ_W-1:0]   dqIn,
  output logic [LANES-1:0]  laneFull,
  output logic              wrValid,
  output logic [WORD_W-1:0] wrWord,
  output logic [DQ_W-1:0]   dqOut,
  output logic              dqOe,
  output logic [LANES-1:0]  dqsOut,
  output logic              dqsOe
);
  localparam int FILL_W = $clog2(BEATS + 1);

  // read path: shift register, lowest slice on the pins
  logic [WORD_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN)          shiftReg <= '0;
    else if (ctl.load)  shiftReg <= rdWord;
    else if (ctl.shift) shiftReg <= shiftReg >> DQ_W;
  end

  assign dqOut  = ctl.dqOe ? shiftReg[DQ_W-1:0] : '0;
  assign dqOe   = ctl.dqOe;
  assign dqsOe  = ctl.dqsOe;
  assign dqsOut = {LANES{ctl.dqsLevel}};

  // write path: one collector per lane, each on its own strobe
  logic [WORD_W-1:0] laneWord;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic                             prevLvl;
    logic [FILL_W-1:0]                fill;
    logic [BEATS-1:0][LANE_W-1:0]     beatBuf;
    logic                             strobeEdge;
    logic [LANE_W-1:0]                laneDq;

    assign laneDq      = dqIn[l*LANE_W +: LANE_W];
    assign strobeEdge  = dqsIn[l] != prevLvl;
    assign laneFull[l] = (fill == FILL_W'(BEATS));

    always_ff @(posedge clk) begin
      if (!rstN || !wrActive) begin
        prevLvl <= 1'b0;
        fill    <= '0;
      end else begin
        prevLvl <= dqsIn[l];
        if (ctl.wrPush) begin
          if (strobeEdge) begin
            beatBuf[0] <= laneDq;
            fill       <= FILL_W'(1);
          end else begin
            fill <= '0;
          end
        end else if (strobeEdge && fill < FILL_W'(BEATS)) begin
          beatBuf[fill[FILL_W-2:0]] <= laneDq;
          fill                      <= fill + 1'b1;
        end
      end
    end

    for (genvar k = 0; k < BEATS; k++) begin : g_beat
      assign laneWord[k*DQ_W + l*LANE_W +: LANE_W] = beatBuf[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrValid <= 1'b0;
      wrWord  <= '0;
    end else begin
      wrValid <= ctl.wrPush;
      if (ctl.wrPush) wrWord <= laneWord;
    end
  end
endmodule

// File: rtl/burst_serdes.sv
module burst_serdes
  import burst_serdes_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANES  = 1,
  localparam int DQ_W   = LANE_W * LANES,
  localparam int WORD_W = DQ_W * BEATS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdValid,
  output logic              rdReady,
  input  logic [WORD_W-1:0] rdWord,
  input  logic              wrActive,
  input  logic [LANES-1:0]  dqsIn,
  input  logic [DQ_W-1:0]   dqIn,
  output logic              wrValid,
  output logic [WORD_W-1:0] wrWord,
  output logic [DQ_W-1:0]   dqOut,
  output logic              dqOe,
  output logic [LANES-1:0]  dqsOut,
  output logic              dqsOe
);
  pfsCtl_t          ctl;
  logic [LANES-1:0] laneFull;

  burst_serdes_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .rdValid(rdValid), .rdReady(rdReady),
    .laneFull(laneFull), .ctl(ctl)
  );

  burst_serdes_dp #(.LANE_W(LANE_W), .LANES(LANES)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rdWord(rdWord),
    .wrActive(wrActive), .dqsIn(dqsIn), .dqIn(dqIn), .laneFull(laneFull),
    .wrValid(wrValid), .wrWord(wrWord), .dqOut(dqOut), .dqOe(dqOe),
    .dqsOut(dqsOut), .dqsOe(dqsOe)
  );
endmodule

// File: rtl/burst_serdes_chk.sv
module burst_serdes_chk #(
  parameter int LANE_W = 8,
  parameter int LANES  = 1,
  localparam int DQ_W  = LANE_W * LANES
) (
  input logic             clk,
  input logic             rstN,
  input logic             rdValid,
  input logic             rdReady,
  input logic             wrValid,
  input logic [DQ_W-1:0]  dqOut,
  input logic             dqOe,
  input logic [LANES-1:0] dqsOut,
  input logic             dqsOe
);
  AST_PREAMBLE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && rdReady |=> dqsOe && !dqOe && dqsOut == '0); // R2
  AST_FIRST_BEAT_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    dqOe && !$past(dqOe) |-> dqsOut[0]); // R4
  AST_STROBE_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    dqOe && $past(dqOe) |-> dqsOut[0] != $past(dqsOut[0])); // R4
  AST_RELEASE_TOGETHER: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dqOe) |-> !dqsOe); // R5
  AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    rdReady != dqsOe); // R6
  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rstN)
    !dqOe |-> dqOut == '0); // R7
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> !wrValid); // R9
endmodule

bind burst_serdes burst_serdes_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (.*);

// File: tb/burst_serdes_tb.sv
module burst_serdes_tb;
  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int DQ_W   = LANE_W * LANES;
  localparam int WORD_W = DQ_W * 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              rdValid = 1'b0;
  logic              rdReady;
  logic [WORD_W-1:0] rdWord = '0;
  logic              wrActive = 1'b0;
  logic [LANES-1:0]  dqsIn = '0;
  logic [DQ_W-1:0]   dqIn = '0;
  logic              wrValid;
  logic [WORD_W-1:0] wrWord;
  logic [DQ_W-1:0]   dqOut;
  logic              dqOe;
  logic [LANES-1:0]  dqsOut;
  logic              dqsOe;

  always #2 clk = ~clk; // 250 MHz

  burst_serdes #(.LANE_W(LANE_W), .LANES(LANES)) u_dut (.*);

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic [DQ_W:0]     rdExpQ[$];   // {strobe level, data}
  logic [WORD_W-1:0] wrExpQ[$];

  task automatic check(input bit ok, input string req, input logic [WORD_W-1:0] act,
                       input logic [WORD_W-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // read driver: waits for ready, offers a word, queues its beats
  task automatic sendRead(input logic [WORD_W-1:0] w);
    @(negedge clk);
    while (!rdReady) @(negedge clk);
    rdValid = 1'b1;
    rdWord  = w;
    for (int k = 0; k < 4; k++) rdExpQ.push_back({~k[0], w[k*DQ_W +: DQ_W]});
    @(negedge clk);
    rdValid = 1'b0;
    check(dqsOe && !dqOe && dqsOut == '0, "R2 preamble", {dqsOe, dqOe, dqsOut}, 4'b1000);
  endtask

  // write driver: lane l starts skew[l] cycles late
  task automatic sendWrite(input logic [WORD_W-1:0] w, input int skew1, input bit queueIt);
    wrActive = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 4 + skew1; c++) begin
      @(negedge clk);
      for (int l = 0; l < LANES; l++) begin
        int b;
        b = c - ((l == 1) ? skew1 : 0);
        if (b >= 0 && b < 4) begin
          dqIn[l*LANE_W +: LANE_W] = w[b*DQ_W + l*LANE_W +: LANE_W];
          dqsIn[l] = ~b[0];
        end
      end
    end
    if (queueIt) wrExpQ.push_back(w);
    repeat (3) @(negedge clk);
  endtask

  // read monitor
  int beatRun = 0;
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (dqOe) begin
        if (rdExpQ.size() == 0) check(0, "R3 unexpected beat", dqOut, 0);
        else begin
          logic [DQ_W:0] e;
          e = rdExpQ.pop_front();
          check(dqOut == e[DQ_W-1:0], "R3 beat data", dqOut, e[DQ_W-1:0]);
          check(dqsOut == {LANES{e[DQ_W]}} && dqsOe, "R4 strobe level", dqsOut, {LANES{e[DQ_W]}});
        end
        beatRun++;
      end else begin
        check(dqOut == '0, "R7 idle bus", dqOut, 0);
        if (beatRun != 0) begin
          check(beatRun == 4, "R3 burst length", beatRun, 4);
          check(!dqsOe, "R5 strobe released", dqsOe, 0);
          beatRun = 0;
        end
      end
      check(rdReady == !dqsOe, "R6 ready vs strobe", rdReady, !dqsOe);
    end
  end

  // write monitor
  logic lastWrValid = 1'b0;
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (wrValid) begin
        check(!lastWrValid, "R9 single pulse", lastWrValid, 0);
        if (wrExpQ.size() == 0) check(0, "R10 unexpected word", wrWord, 0);
        else begin
          logic [WORD_W-1:0] e;
          e = wrExpQ.pop_front();
          check(wrWord == e, "R8 write word", wrWord, e);
        end
      end
      lastWrValid = wrValid;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rdReady && !dqOe && !dqsOe && !wrValid, "R1 in reset",
          {rdReady, dqOe, dqsOe, wrValid}, 4'b1000);
    rstN = 1'b1;
    @(negedge clk);
    check(rdReady && !dqOe && !dqsOe && !wrValid, "R1 after reset",
          {rdReady, dqOe, dqsOe, wrValid}, 4'b1000);

    // R3 R4 several patterns, back to back
    sendRead(64'h0123_4567_89AB_CDEF);
    sendRead(64'hFFFF_0000_FFFF_0000);
    sendRead(64'h0000_0000_0000_0001);
    sendRead(64'h8000_0000_0000_0000);

    // R6: word offered mid-burst is not taken
    sendRead(64'hDEAD_BEEF_CAFE_F00D);
    rdValid = 1'b1;
    rdWord  = 64'h1111_2222_3333_4444;
    @(negedge clk);
    check(!rdReady, "R6 busy", rdReady, 0);
    @(negedge clk);
    rdValid = 1'b0;
    repeat (4) @(negedge clk);
    check(!dqsOe && !dqOe, "R6 no extra burst", {dqsOe, dqOe}, 0);

    // R8 aligned lanes, R9 skewed lanes
    sendWrite(64'hA1B2_C3D4_E5F6_0718, 0, 1);
    sendWrite(64'h0F1E_2D3C_4B5A_6978, 1, 1);
    sendWrite(64'h5555_AAAA_1234_8765, 2, 1);

    // R10: partial burst dropped by wrActive low
    wrActive = 1'b1;
    @(negedge clk);
    for (int b = 0; b < 2; b++) begin
      @(negedge clk);
      dqIn  = 16'h9999;
      dqsIn = {LANES{~b[0]}};
    end
    @(negedge clk);
    wrActive = 1'b0;
    repeat (2) @(negedge clk);
    check(!wrValid, "R10 no word from partial", wrValid, 0);
    sendWrite(64'h7777_6666_5555_4444, 0, 1);
    wrActive = 1'b0;

    repeat (4) @(negedge clk);
    check(rdExpQ.size() == 0, "R3 all beats seen", rdExpQ.size(), 0);
    check(wrExpQ.size() == 0, "R9 all words seen", wrExpQ.size(), 0);
    finish_run();
  end
endmodule